// File: doc/BRIEF.md
# Accumulator Datapath with Carry Flag

This block is the arithmetic core of a small accumulator machine. A single 32-bit accumulator is the destination of every computing operation. A sequencer drives a one-cycle operation strobe together with an operation code. The block computes every candidate result in parallel, and a selector picks the one that the code names. The accumulator and the other registers load on the clock edge that samples the strobe.

Around the accumulator the block holds these registers:
- two scratch registers, X and Y;
- a high and a low product register, which together receive a full double-width product;
- a one-bit carry flag;
- an output port register.

Operands come from four places: the general-purpose register input, an input port, the internal registers, and an external floating-point result input. That last input lets a separate floating-point unit deliver its result through the same accumulator path. Control is plain: a strobe and a code, with no back-pressure, because every operation completes in one cycle.

Top module: `accum_alu`

## Requirements
- R1: After reset, the accumulator, X, Y, Hi, Lo, the flag and the output port are all zero.
- R2: Code 8 (add) loads Acc+GPR into Acc and sets the flag to the carry out. Code 15 (increment) loads Acc+1 and sets the flag to its carry. Code 21 (subtract) loads Acc−GPR modulo 2^W and leaves the flag unchanged. Code 7 (decrement) loads Acc−1, wrapping from 0 to all ones, and leaves the flag unchanged.
- R3: Code 22 stores the unsigned double-width product Acc×GPR, with the upper half in Hi and the lower half in Lo. Code 24 copies Hi into Acc and code 25 copies Lo into Acc.
- R4: Code 28 copies Acc into X and code 29 copies Acc into Y. Code 16 loads X into Acc and code 17 loads Y into Acc. Code 18 loads X AND Y into Acc, and code 19 loads X OR Y.
- R5: Code 23 shifts Acc one place toward the MSB, inserts 0 and loads the flag with the old MSB. Code 13 shifts Acc toward the LSB, inserts 0 and loads the flag with the old LSB.
- R6: Code 11 rotates Acc one place toward the MSB (the old MSB enters bit 0). Code 10 rotates toward the LSB. Neither touches the flag.
- R7: Code 12 complements Acc. Code 9 loads GPR, code 20 loads the input port and code 26 loads the floating-point result input. None of these four changes the flag.
- R8: Code 14 loads Acc with 1 when Acc ≤ X (unsigned) and with 0 otherwise.
- R9: Codes 1 to 6 clear one register each, in the order Acc, X, Y, Hi, Lo, flag, and leave the others unchanged.
- R10: Code 27 copies Acc to the output port register. The port register holds its value under every other code.
- R11: With the strobe low, or with codes 0, 30 or 31, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_en | input | 1 | Operation strobe, one cycle per operation |
| op_code | input | 5 | Operation code, sampled with op_en |
| gpr_in | input | W | General-purpose register operand |
| port_in | input | W | Input port operand |
| fp_in | input | W | Result from the external floating-point unit |
| acc_out | output | W | Accumulator |
| flag_out | output | 1 | Carry flag |
| port_out | output | W | Output port register |

## Verification
On every cycle, the assertions check the carry of add and the double-width product. They also check that the flag is left alone by subtract and by both rotates, that a left shift moves the MSB into the flag, that compare produces only 0 or 1, that the port register holds except under its own code, and that all state freezes while the strobe is low. The bench is needed for the rest: the exact values across sweeps of operand pairs, the read-back of Hi, Lo, X and Y through the accumulator, the decrement wrap at zero, and the proof that each clear code touches only its own register.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;
  typedef enum logic [4:0] {
    OP_NOP    = 5'd0,
    OP_CLR_A  = 5'd1,
    OP_CLR_X  = 5'd2,
    OP_CLR_Y  = 5'd3,
    OP_CLR_HI = 5'd4,
    OP_CLR_LO = 5'd5,
    OP_CLR_F  = 5'd6,
    OP_DEC    = 5'd7,
    OP_ADD    = 5'd8,
    OP_LD_GPR = 5'd9,
    OP_ROR    = 5'd10,
    OP_ROL    = 5'd11,
    OP_NOT    = 5'd12,
    OP_SHR    = 5'd13,
    OP_CMP_X  = 5'd14,
    OP_INC    = 5'd15,
    OP_LD_X   = 5'd16,
    OP_LD_Y   = 5'd17,
    OP_AND_XY = 5'd18,
    OP_OR_XY  = 5'd19,
    OP_LD_PIN = 5'd20,
    OP_SUB    = 5'd21,
    OP_MUL    = 5'd22,
    OP_SHL    = 5'd23,
    OP_LD_HI  = 5'd24,
    OP_LD_LO  = 5'd25,
    OP_LD_FP  = 5'd26,
    OP_PORT   = 5'd27,
    OP_ST_X   = 5'd28,
    OP_ST_Y   = 5'd29
  } alu_op_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] gpr,
  input  logic [W-1:0] x,
  output logic [W-1:0] sum,
  output logic         sum_c,
  output logic [W-1:0] diff,
  output logic [W-1:0] incr,
  output logic         incr_c,
  output logic [W-1:0] decr,
  output logic         le_x
);
  localparam int WE = W + 1;
  logic [WE-1:0] sum_w, inc_w;

  always_comb begin
    sum_w  = {1'b0, acc} + {1'b0, gpr};
    inc_w  = {1'b0, acc} + WE'(1);
    sum    = sum_w[W-1:0];
    sum_c  = sum_w[W];
    incr   = inc_w[W-1:0];
    incr_c = inc_w[W];
    diff   = acc - gpr;
    decr   = acc - W'(1);
    le_x   = (acc <= x);
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] and_xy,
  output logic [W-1:0] or_xy,
  output logic [W-1:0] inv,
  output logic [W-1:0] shl,
  output logic         shl_out,
  output logic [W-1:0] shr,
  output logic         shr_out,
  output logic [W-1:0] rol,
  output logic [W-1:0] ror
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign and_xy[i] = x[i] & y[i];
      assign or_xy[i]  = x[i] | y[i];
      assign inv[i]    = ~acc[i];
      if (i == 0) begin : g_lsb
        assign shl[i] = 1'b0;
        assign rol[i] = acc[W-1];
      end else begin : g_up
        assign shl[i] = acc[i-1];
        assign rol[i] = acc[i-1];
      end
      if (i == W-1) begin : g_msb
        assign shr[i] = 1'b0;
        assign ror[i] = acc[0];
      end else begin : g_dn
        assign shr[i] = acc[i+1];
        assign ror[i] = acc[i+1];
      end
    end
  endgenerate

  assign shl_out = acc[W-1];
  assign shr_out = acc[0];
endmodule

// File: rtl/alu_mult.sv
module alu_mult #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   prod_hi,
  output logic [W-1:0]   prod_lo
);
  localparam int PW = 2 * W;
  logic [PW-1:0] prod;

  always_comb begin
    prod    = PW'(a) * PW'(b);
    prod_hi = prod[PW-1:W];
    prod_lo = prod[W-1:0];
  end
endmodule

// File: rtl/accum_alu.sv
module accum_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_en,
  input  logic [4:0]   op_code,
  input  logic [W-1:0] gpr_in,
  input  logic [W-1:0] port_in,
  input  logic [W-1:0] fp_in,
  output logic [W-1:0] acc_out,
  output logic         flag_out,
  output logic [W-1:0] port_out
);
  import accum_alu_pkg::*;

  logic [W-1:0] acc_q, x_q, y_q, hi_q, lo_q, port_q;
  logic         f_q;
  logic [W-1:0] acc_d, x_d, y_d, hi_d, lo_d, port_d;
  logic         f_d;

  logic [W-1:0] sum, diff, incr, decr;
  logic         sum_c, incr_c, le_x;
  logic [W-1:0] and_xy, or_xy, inv, shl, shr, rol, ror;
  logic         shl_out, shr_out;
  logic [W-1:0] prod_hi, prod_lo;
  alu_op_e      op;

  alu_arith #(.W(W)) u_arith (
    .acc(acc_q), .gpr(gpr_in), .x(x_q),
    .sum(sum), .sum_c(sum_c), .diff(diff),
    .incr(incr), .incr_c(incr_c), .decr(decr), .le_x(le_x)
  );

  alu_bitops #(.W(W)) u_bits (
    .acc(acc_q), .x(x_q), .y(y_q),
    .and_xy(and_xy), .or_xy(or_xy), .inv(inv),
    .shl(shl), .shl_out(shl_out), .shr(shr), .shr_out(shr_out),
    .rol(rol), .ror(ror)
  );

  alu_mult #(.W(W)) u_mult (
    .a(acc_q), .b(gpr_in), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  assign op = alu_op_e'(op_code);

  always_comb begin
    acc_d  = acc_q;
    x_d    = x_q;
    y_d    = y_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    f_d    = f_q;
    port_d = port_q;
    if (op_en) begin
      case (op)
        OP_CLR_A:  acc_d = '0;
        OP_CLR_X:  x_d   = '0;
        OP_CLR_Y:  y_d   = '0;
        OP_CLR_HI: hi_d  = '0;
        OP_CLR_LO: lo_d  = '0;
        OP_CLR_F:  f_d   = 1'b0;
        OP_DEC:    acc_d = decr;
        OP_ADD:    begin acc_d = sum;  f_d = sum_c;  end
        OP_LD_GPR: acc_d = gpr_in;
        OP_ROR:    acc_d = ror;
        OP_ROL:    acc_d = rol;
        OP_NOT:    acc_d = inv;
        OP_SHR:    begin acc_d = shr;  f_d = shr_out; end
        OP_CMP_X:  acc_d = {{(W-1){1'b0}}, le_x};
        OP_INC:    begin acc_d = incr; f_d = incr_c; end
        OP_LD_X:   acc_d = x_q;
        OP_LD_Y:   acc_d = y_q;
        OP_AND_XY: acc_d = and_xy;
        OP_OR_XY:  acc_d = or_xy;
        OP_LD_PIN: acc_d = port_in;
        OP_SUB:    acc_d = diff;
        OP_MUL:    begin hi_d = prod_hi; lo_d = prod_lo; end
        OP_SHL:    begin acc_d = shl;  f_d = shl_out; end
        OP_LD_HI:  acc_d = hi_q;
        OP_LD_LO:  acc_d = lo_q;
        OP_LD_FP:  acc_d = fp_in;
        OP_PORT:   port_d = acc_q;
        OP_ST_X:   x_d = acc_q;
        OP_ST_Y:   y_d = acc_q;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      x_q    <= '0;
      y_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      f_q    <= 1'b0;
      port_q <= '0;
    end else begin
      acc_q  <= acc_d;
      x_q    <= x_d;
      y_q    <= y_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      f_q    <= f_d;
      port_q <= port_d;
    end
  end

  assign acc_out  = acc_q;
  assign flag_out = f_q;
  assign port_out = port_q;
endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_en,
  input logic [4:0]   op_code,
  input logic [W-1:0] gpr_in,
  input logic [W-1:0] acc_q,
  input logic         f_q,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q,
  input logic [W-1:0] port_q
);
  import accum_alu_pkg::*;

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OP_ADD) |=>
      ({f_q, acc_q} == ((W+1)'($past(acc_q)) + (W+1)'($past(gpr_in))))); // R2

  AST_SUB_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OP_SUB) |=> (f_q == $past(f_q))); // R2

  AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OP_MUL) |=>
      ({hi_q, lo_q} == ((2*W)'($past(acc_q)) * (2*W)'($past(gpr_in))))); // R3

  AST_SHL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OP_SHL) |=>
      (f_q == $past(acc_q[W-1]) && acc_q[0] == 1'b0)); // R5

  AST_ROT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_code == OP_ROL || op_code == OP_ROR)) |=> $stable(f_q)); // R6

  AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OP_CMP_X) |=> (acc_q[W-1:1] == '0)); // R8

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_en && op_code == OP_PORT) |=> $stable(port_q)); // R10

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> ($stable(acc_q) && $stable(f_q) && $stable(hi_q) && $stable(lo_q))); // R11
endmodule

bind accum_alu accum_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
  .gpr_in(gpr_in), .acc_q(acc_q), .f_q(f_q), .hi_q(hi_q),
  .lo_q(lo_q), .port_q(port_q)
);

// File: tb/accum_alu_test.sv
module accum_alu_test;
  localparam int W = 8;
  localparam int M = (1 << W) - 1;

  localparam logic [4:0] C_CLR_A = 5'd1,  C_CLR_X = 5'd2,  C_CLR_Y = 5'd3;
  localparam logic [4:0] C_CLR_HI = 5'd4, C_CLR_LO = 5'd5, C_CLR_F = 5'd6;
  localparam logic [4:0] C_DEC = 5'd7,  C_ADD = 5'd8,  C_LDG = 5'd9;
  localparam logic [4:0] C_ROR = 5'd10, C_ROL = 5'd11, C_NOT = 5'd12;
  localparam logic [4:0] C_SHR = 5'd13, C_CMP = 5'd14, C_INC = 5'd15;
  localparam logic [4:0] C_LDX = 5'd16, C_LDY = 5'd17, C_AND = 5'd18;
  localparam logic [4:0] C_OR = 5'd19,  C_PIN = 5'd20, C_SUB = 5'd21;
  localparam logic [4:0] C_MUL = 5'd22, C_SHL = 5'd23, C_LHI = 5'd24;
  localparam logic [4:0] C_LLO = 5'd25, C_LFP = 5'd26, C_PORT = 5'd27;
  localparam logic [4:0] C_STX = 5'd28, C_STY = 5'd29;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_en = 1'b0;
  logic [4:0]   op_code = '0;
  logic [W-1:0] gpr_in = '0, port_in = '0, fp_in = '0;
  logic [W-1:0] acc_out, port_out;
  logic         flag_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic ef;

  accum_alu #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
    .gpr_in(gpr_in), .port_in(port_in), .fp_in(fp_in),
    .acc_out(acc_out), .flag_out(flag_out), .port_out(port_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [4:0] c);
    @(negedge clk);
    op_en = 1'b1;
    op_code = c;
    @(negedge clk);
    op_en = 1'b0;
  endtask

  task automatic set_acc(input int v);
    gpr_in = W'(v);
    do_op(C_LDG);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, internal registers read back through Acc
    check("R1 acc", acc_out, 0);
    check("R1 flag", flag_out, 0);
    check("R1 port", port_out, 0);
    do_op(C_LDX); check("R1 x", acc_out, 0);
    do_op(C_LDY); check("R1 y", acc_out, 0);
    do_op(C_LHI); check("R1 hi", acc_out, 0);
    do_op(C_LLO); check("R1 lo", acc_out, 0);

    // R2 add/sub sweep
    for (int a = 0; a <= M; a += 15) begin
      for (int b = 0; b <= M; b += 11) begin
        set_acc(a); gpr_in = W'(b); do_op(C_ADD);
        check("R2 add", acc_out, (a + b) & M);
        check("R2 add carry", flag_out, (a + b) >> W);
        ef = flag_out;
        set_acc(a); gpr_in = W'(b); do_op(C_SUB);
        check("R2 sub", acc_out, (a - b) & M);
        check("R2 sub flag", flag_out, ef);
      end
    end
    // R2 inc/dec over every value
    for (int a = 0; a <= M; a++) begin
      set_acc(a); do_op(C_INC);
      check("R2 inc", acc_out, (a + 1) & M);
      check("R2 inc carry", flag_out, (a == M) ? 1 : 0);
      ef = flag_out;
      set_acc(a); do_op(C_DEC);
      check("R2 dec", acc_out, (a + M) & M);
      check("R2 dec flag", flag_out, ef);
    end

    // R3 multiply
    for (int a = 0; a <= M; a += 17) begin
      for (int b = 0; b <= M; b += 13) begin
        set_acc(a); gpr_in = W'(b); do_op(C_MUL);
        do_op(C_LHI); check("R3 hi", acc_out, (a * b) >> W);
        do_op(C_LLO); check("R3 lo", acc_out, (a * b) & M);
      end
    end

    // R4 X/Y logic, R8 compare
    for (int a = 0; a <= M; a += 23) begin
      for (int b = 0; b <= M; b += 29) begin
        set_acc(a); do_op(C_STX);
        set_acc(b); do_op(C_STY);
        do_op(C_AND); check("R4 and", acc_out, a & b);
        do_op(C_OR);  check("R4 or", acc_out, a | b);
        do_op(C_LDX); check("R4 ldx", acc_out, a);
        do_op(C_LDY); check("R4 ldy", acc_out, b);
        set_acc(b); do_op(C_CMP);
        check("R8 cmp", acc_out, (b <= a) ? 1 : 0);
        set_acc(a); do_op(C_CMP);
        check("R8 cmp equal", acc_out, 1);
      end
    end

    // R5 shifts, R6 rotates, R7 complement over every value
    for (int a = 0; a <= M; a++) begin
      set_acc(a); do_op(C_SHL);
      check("R5 shl", acc_out, (a << 1) & M);
      check("R5 shl flag", flag_out, (a >> (W - 1)) & 1);
      set_acc(a); do_op(C_SHR);
      check("R5 shr", acc_out, a >> 1);
      check("R5 shr flag", flag_out, a & 1);
      ef = flag_out;
      set_acc(a); do_op(C_ROL);
      check("R6 rol", acc_out, ((a << 1) | (a >> (W - 1))) & M);
      check("R6 rol flag", flag_out, ef);
      set_acc(a); do_op(C_ROR);
      check("R6 ror", acc_out, ((a >> 1) | (a << (W - 1))) & M);
      check("R6 ror flag", flag_out, ef);
      set_acc(a); do_op(C_NOT);
      check("R7 not", acc_out, (~a) & M);
      check("R7 not flag", flag_out, ef);
    end

    // R7 operand loads
    port_in = 8'h5A; fp_in = 8'hC3;
    do_op(C_PIN); check("R7 port in", acc_out, 'h5A);
    do_op(C_LFP); check("R7 fp in", acc_out, 'hC3);
    set_acc('h3C); check("R7 gpr", acc_out, 'h3C);

    // R9 individual clears
    set_acc('hFF); do_op(C_INC);
    set_acc('hA5); do_op(C_STX);
    set_acc('h96); do_op(C_STY);
    gpr_in = 8'hF1; set_acc('hE7); gpr_in = 8'hF1; do_op(C_MUL);
    check("R9 flag set", flag_out, 1);
    do_op(C_CLR_X);
    do_op(C_LDX); check("R9 clr x", acc_out, 0);
    do_op(C_LDY); check("R9 y kept", acc_out, 'h96);
    do_op(C_CLR_Y);
    do_op(C_LDY); check("R9 clr y", acc_out, 0);
    do_op(C_LHI); check("R9 hi kept", acc_out, ('hE7 * 'hF1) >> W);
    do_op(C_CLR_HI);
    do_op(C_LHI); check("R9 clr hi", acc_out, 0);
    do_op(C_LLO); check("R9 lo kept", acc_out, ('hE7 * 'hF1) & M);
    check("R9 flag kept", flag_out, 1);
    do_op(C_CLR_LO);
    do_op(C_LLO); check("R9 clr lo", acc_out, 0);
    do_op(C_CLR_F); check("R9 clr f", flag_out, 0);
    set_acc('h77); do_op(C_CLR_A); check("R9 clr acc", acc_out, 0);

    // R10 output port
    set_acc('h6B); do_op(C_PORT); check("R10 port", port_out, 'h6B);
    set_acc('h12); do_op(C_ADD); check("R10 port hold", port_out, 'h6B);

    // R11 strobe low and unused codes
    set_acc('h4E); do_op(C_INC); ef = flag_out;
    @(negedge clk); op_code = C_CLR_A; gpr_in = 8'hFF;
    repeat (4) @(negedge clk);
    check("R11 idle acc", acc_out, 'h4F);
    for (int c = 30; c <= 31; c++) begin
      do_op(5'(c));
      check("R11 unused acc", acc_out, 'h4F);
      check("R11 unused flag", flag_out, ef);
      check("R11 unused port", port_out, 'h6B);
    end
    do_op(5'd0);
    check("R11 nop acc", acc_out, 'h4F);
    do_op(C_LHI); check("R11 hi kept", acc_out, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule